// File: doc/BRIEF.md
# Area-Reduced Carry-Select Adder

This block adds two unsigned operands of a parameterised width together with a single carry-in bit. It returns a sum of the same width and a carry-out. It is meant to be the addition stage inside a modular multiplier datapath. The block is purely combinational, so it has no clock and no reset.

One ripple chain of full-adder cells computes the result that applies when the carry-in is zero. An increment network then derives the carry-in-one result from that first result. The increment network toggles each bit whose lower bits are all ones, and it takes the place of the second ripple chain that a classic carry-select adder would need. A final row of 2:1 multiplexers, steered by the real carry-in, picks the sum and the carry-out. A build-time parameter can restore the classic form, where a second ripple chain is hard-wired to carry-in one, so that the two forms can be compared. Both forms give bit-identical outputs.

Top module: `cs_adder_b1`

## Requirements
- R1: With the increment variant selected, `{cout_o, sum_o}` always equals the arithmetic value a_i + b_i + cin_i, taken WIDTH+1 bits wide.
- R2: With the dual-ripple variant selected (VARIANT = VAR_DUAL_RIPPLE), the outputs are identical to those of the increment variant for every input.
- R3: When cin_i is 0, `{cout_o, sum_o}` equals a_i + b_i, with no increment applied.
- R4: When both operands are all ones and cin_i is 1, sum_o is all ones and cout_o is 1.
- R5: When both operands are zero, sum_o equals cin_i (zero-extended) and cout_o is 0.
- R6: When cin_i is 1, cout_o is 1 exactly when the carry-in-zero chain produces a carry or its sum is all ones. For example, a_i = all ones, b_i = 0 and cin_i = 1 give sum 0 and carry-out 1.
- R7: For fixed operands, raising cin_i from 0 to 1 increases the value `{cout_o, sum_o}` by exactly one.
- R8: R1 and R2 hold for widths other than 8. This is shown at a width of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in, also the final multiplexer select |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry-out |

## Verification
At 8 bits, every pair of operands is applied under both carry-in values. Each result is compared with an arithmetic sum, and the two variants are compared with each other. This separates a fault in the ripple chain (visible under carry-in zero) from a fault in the increment network or the multiplexers (visible only under carry-in one). Directed points then isolate the carry-out path:
- all-ones operands;
- zero operands;
- an all-ones sum with a zero chain carry.

Under each of these, toggling carry-in alone must move the result by exactly one. Random operands at 32 bits show that the prefix logic of the increment network scales beyond the swept width.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef enum logic {
    VAR_ADD_ONE     = 1'b0,
    VAR_DUAL_RIPPLE = 1'b1
  } csa_variant_e;
endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & p);
endmodule

// File: rtl/csa_ripple_chain.sv
module csa_ripple_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);
  logic [WIDTH:0] carry;
  assign carry[0] = c_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    csa_fa_cell u_fa (
      .a_i(a_i[i]),
      .b_i(b_i[i]),
      .c_i(carry[i]),
      .s_o(s_o[i]),
      .c_o(carry[i+1])
    );
  end

  assign c_o = carry[WIDTH];
endmodule

// File: rtl/csa_excess_one.sv
// Adds one by toggle logic: bit i flips when every lower bit is set.
module csa_excess_one #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned VW   = WIDTH + 1
) (
  input  logic [VW-1:0] val_i,
  output logic [VW-1:0] inc_o
);
  logic [VW-1:0] low_ones;
  assign low_ones[0] = 1'b1;

  for (genvar i = 1; i < VW; i++) begin : g_pfx
    assign low_ones[i] = low_ones[i-1] & val_i[i-1];
  end

  for (genvar i = 0; i < VW; i++) begin : g_tgl
    assign inc_o[i] = val_i[i] ^ low_ones[i];
  end
endmodule

// File: rtl/csa_sel_mux.sv
module csa_sel_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sel_i,
  input  logic [WIDTH-1:0] d0_i,
  input  logic [WIDTH-1:0] d1_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q_o[i] = sel_i ? d1_i[i] : d0_i[i];
  end
endmodule

// File: rtl/cs_adder_b1.sv
module cs_adder_b1
  import csa_pkg::*;
#(
  parameter int unsigned  WIDTH   = 8,
  parameter csa_variant_e VARIANT = VAR_ADD_ONE,
  localparam int unsigned RW      = WIDTH + 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] s0;
  logic             c0;
  logic [RW-1:0]    res0;
  logic [RW-1:0]    res1;
  logic [RW-1:0]    res;

  csa_ripple_chain #(.WIDTH(WIDTH)) u_chain0 (
    .a_i(a_i),
    .b_i(b_i),
    .c_i(1'b0),
    .s_o(s0),
    .c_o(c0)
  );

  assign res0 = {c0, s0};

  if (VARIANT == VAR_ADD_ONE) begin : g_add_one
    csa_excess_one #(.WIDTH(WIDTH)) u_inc (
      .val_i(res0),
      .inc_o(res1)
    );
  end else begin : g_dual
    logic [WIDTH-1:0] s1;
    logic             c1;
    csa_ripple_chain #(.WIDTH(WIDTH)) u_chain1 (
      .a_i(a_i),
      .b_i(b_i),
      .c_i(1'b1),
      .s_o(s1),
      .c_o(c1)
    );
    assign res1 = {c1, s1};
  end

  csa_sel_mux #(.WIDTH(RW)) u_sel (
    .sel_i(cin_i),
    .d0_i(res0),
    .d1_i(res1),
    .q_o(res)
  );

  assign sum_o  = res[WIDTH-1:0];
  assign cout_o = res[WIDTH];
endmodule

// File: rtl/cs_adder_b1_chk.sv
module cs_adder_b1_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_i,
  input logic             cout_i,
  input logic [WIDTH-1:0] s0_i,
  input logic             c0_i
);
  logic [WIDTH:0] ref_sum;
  logic [WIDTH:0] ref_nocin;
  assign ref_nocin = {1'b0, a_i} + {1'b0, b_i};
  assign ref_sum   = ref_nocin + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    // R1 / R2 / R8
    a_r1_sum_matches: assert ({cout_i, sum_i} == ref_sum)
      else $error("a_r1_sum_matches");
    // R3
    a_r3_cin0_plain: assert (cin_i || ({cout_i, sum_i} == ref_nocin))
      else $error("a_r3_cin0_plain");
    // R4
    a_r4_all_ones: assert (!(cin_i && (&a_i) && (&b_i)) || (cout_i && (&sum_i)))
      else $error("a_r4_all_ones");
    // R5
    a_r5_zero_ops: assert (!((a_i == '0) && (b_i == '0)) ||
                           (!cout_i && (sum_i == {{(WIDTH-1){1'b0}}, cin_i})))
      else $error("a_r5_zero_ops");
    // R6
    a_r6_cout_sel: assert (!cin_i || (cout_i == (c0_i | (&s0_i))))
      else $error("a_r6_cout_sel");
    // R7: chain result is always one below the carry-in-one result
    a_r7_step_one: assert (!cin_i || ({cout_i, sum_i} == ({c0_i, s0_i} + 1'b1)))
      else $error("a_r7_step_one");
  end
endmodule

bind cs_adder_b1 cs_adder_b1_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i),
  .b_i(b_i),
  .cin_i(cin_i),
  .sum_i(sum_o),
  .cout_i(cout_o),
  .s0_i(s0),
  .c0_i(c0)
);

// File: tb/sim_cs_adder_b1.sv
`timescale 1ns/1ps
module sim_cs_adder_b1;
  import csa_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  a8, b8;
  logic        c8;
  logic [7:0]  s_inc8, s_dual8;
  logic        co_inc8, co_dual8;
  logic [31:0] a32, b32;
  logic        c32;
  logic [31:0] s_inc32, s_dual32;
  logic        co_inc32, co_dual32;

  cs_adder_b1 #(.WIDTH(8), .VARIANT(VAR_ADD_ONE)) u0 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s_inc8), .cout_o(co_inc8));
  cs_adder_b1 #(.WIDTH(8), .VARIANT(VAR_DUAL_RIPPLE)) u1 (
    .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s_dual8), .cout_o(co_dual8));
  cs_adder_b1 #(.WIDTH(32), .VARIANT(VAR_ADD_ONE)) u2 (
    .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s_inc32), .cout_o(co_inc32));
  cs_adder_b1 #(.WIDTH(32), .VARIANT(VAR_DUAL_RIPPLE)) u3 (
    .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s_dual32), .cout_o(co_dual32));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b, input logic c);
    a8 = a; b8 = b; c8 = c;
    #0.5;
  endtask

  initial begin
    logic [8:0] r0;
    logic [8:0] exp9;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    #2 rst_ni = 1'b1;

    // R5: idle/zero state
    apply8(8'h00, 8'h00, 1'b0);
    check("R5 zero cin0", {co_inc8, s_inc8}, 9'h000);
    #0.5;
    apply8(8'h00, 8'h00, 1'b1);
    check("R5 zero cin1", {co_inc8, s_inc8}, 9'h001);
    #0.5;
    // R4
    apply8(8'hFF, 8'hFF, 1'b1);
    check("R4 all ones cin1", {co_inc8, s_inc8}, 9'h1FF);
    check("R4 all ones cin1 dual", {co_dual8, s_dual8}, 9'h1FF);
    #0.5;
    // R6: chain sum all ones, no chain carry
    apply8(8'hFF, 8'h00, 1'b1);
    check("R6 all-ones sum cin1", {co_inc8, s_inc8}, 9'h100);
    #0.5;
    apply8(8'h5A, 8'hA5, 1'b1);
    check("R6 propagate cin1", {co_inc8, s_inc8}, 9'h100);
    #0.5;
    apply8(8'h80, 8'h80, 1'b1);
    check("R6 chain carry cin1", {co_inc8, s_inc8}, 9'h101);
    #0.5;
    // R3: cin toggled alone
    apply8(8'hFF, 8'h00, 1'b0);
    check("R3 no increment", {co_inc8, s_inc8}, 9'h0FF);
    #0.5;

    // R1, R2, R3, R7: exhaustive 8-bit sweep
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        exp9 = 9'(a + b);
        apply8(8'(a), 8'(b), 1'b0);
        r0 = {co_inc8, s_inc8};
        check("R3 cin0", r0, exp9);
        check("R2 dual cin0", {co_dual8, s_dual8}, exp9);
        #0.5;
        apply8(8'(a), 8'(b), 1'b1);
        check("R1 cin1", {co_inc8, s_inc8}, exp9 + 9'd1);
        check("R2 dual cin1", {co_dual8, s_dual8}, {co_inc8, s_inc8});
        check("R7 step", {co_inc8, s_inc8} - r0, 9'd1);
        #0.5;
      end
    end

    // R8: wider random operands
    for (int n = 0; n < 2000; n++) begin
      logic [32:0] e33;
      a32 = $urandom;
      b32 = $urandom;
      c32 = n[0];
      if (n == 0) begin a32 = '1; b32 = '1; c32 = 1'b1; end
      if (n == 2) begin a32 = '1; b32 = '0; c32 = 1'b1; end
      e33 = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
      #0.5;
      check("R8 wide inc", {co_inc32, s_inc32}, e33);
      check("R8 wide dual", {co_dual32, s_dual32}, e33);
      #0.5;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule